// File: doc/BRIEF.md
# Windowed Vertical Sync Divider

This block is the digital frame timer of a television deflection chain. It runs at twice the horizontal line rate, so each line spans two counts. It counts those half-lines and decides when a new field starts. A separated vertical sync pulse may restart the count only inside a reset window. An up/down confidence counter picks the window. With low confidence the window is wide, for searching a new signal. With high confidence it is a few counts around the expected field length, which rejects noise and stray pulses.

The count at which an accepted trigger arrives sets a 50/60 Hz flag. The divider uses that flag to place the narrow window and to end the anti-top-flutter gate. This gate is a signal that blanks the horizontal phase detector around vertical sync. A separate out-of-sync flag, driven by a horizontal coincidence detector, makes the divider free-run with a fixed field length. The deflection amplitude then stays steady when there is no input signal. The vertical reset strobe, the two mode flags and the gate go to the sawtooth generator and to the line PLL.

Top module: `vdiv_top`

## Requirements
- R1: After reset the count is 0. No frame strobe is active. The block is in wide-window mode with the 50 Hz flag set, and the gate is high.
- R2: In wide-window mode with no sync, the divider restarts by itself after count 722 (723 clocks per field) and lowers the confidence by 1. Confidence stops at 0.
- R3: In wide-window mode, a sync rising edge at any count from 488 to 722 inclusive restarts the divider and raises the confidence by 1. An edge outside that range does not restart the divider and lowers the confidence by 1.
- R4: A trigger accepted in wide-window mode at a count below 576 clears the 50 Hz flag (60 Hz). One at count 576 or later sets it.
- R5: Confidence is a 4-bit up/down counter that saturates at 15. Narrow mode is entered when it reaches 15.
- R6: Narrow mode is left when the confidence falls below 10.
- R7: In narrow mode, only a rising edge at counts 522..528 (60 Hz) or 622..628 (50 Hz) is accepted. With no accepted edge, the divider restarts after the last window count and the confidence drops by 1.
- R8: The gate falls at count 10 when the 50 Hz flag is set, and at count 12 when it is clear.
- R9: In wide-window mode the gate rises at the restart (count 0). In narrow mode it rises 6 counts before the window start (616 or 516) and stays high through the restart.
- R10: While out-of-sync is high, sync is ignored. The divider restarts after count 625, confidence and both flags hold, and the gate takes its wide-window form.
- R11: The frame strobe is high for exactly one clock, the clock in which the count is 0 after a restart.
- R12: Sync is edge sensitive. A pulse held high counts once, at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the line rate |
| rst_i | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | Separated vertical sync |
| oos_i | input | 1 | Out-of-sync flag from the coincidence detector |
| vrst_o | output | 1 | One-clock frame start strobe |
| std50_o | output | 1 | 1 = 50 Hz field length, 0 = 60 Hz |
| narrow_o | output | 1 | 1 = narrow lock window active |
| gate_o | output | 1 | Anti-top-flutter gate for the phase detector |

## Verification
The bench builds the block with its default parameters: a 10-bit count, a 4-bit confidence counter, and windows at 488..722, 522..528 and 622..628. A field is then at most 723 clocks long, so some forty fields fit in a short run. That is enough to raise the confidence from 0 to saturation in both standards. It also covers decay back below the threshold of 10, every window edge on both sides, the 575/576 standard split, and the out-of-sync free-run with both flags held.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;

  // Outcome of one clock as seen by the divider
  typedef enum logic [2:0] {
    EV_IDLE,      // keep counting
    EV_HIT,       // sync edge inside the active window: restart, confidence up
    EV_TIMEOUT,   // window end without sync: restart, confidence down
    EV_STRAY,     // sync edge outside the window: confidence down only
    EV_FREERUN    // out-of-sync fixed restart
  } vdiv_evt_e;

  function automatic logic evt_restarts(input vdiv_evt_e e);
    return (e == EV_HIT) || (e == EV_TIMEOUT) || (e == EV_FREERUN);
  endfunction

  function automatic logic in_span(input int c, input int lo, input int hi);
    return (c >= lo) && (c <= hi);
  endfunction

  // Saturating confidence step
  function automatic int conf_step(input int c, input int maxv, input logic up, input logic dn);
    if (up) return (c >= maxv) ? maxv : c + 1;
    if (dn) return (c <= 0) ? 0 : c - 1;
    return c;
  endfunction

endpackage

// File: rtl/vdiv_count.sv
module vdiv_count
  import vdiv_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int SRCH_LO  = 488,
  parameter int SRCH_HI  = 722,
  parameter int N60_LO   = 522,
  parameter int N60_HI   = 528,
  parameter int N50_LO   = 622,
  parameter int N50_HI   = 628,
  parameter int FREE_CNT = 625,
  parameter int SPLIT    = 576
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             rise_i,
  input  logic             oos_i,
  input  logic             narrow_i,
  input  logic             std50_i,
  output logic [CNT_W-1:0] cnt_o,
  output vdiv_evt_e        evt_o,
  output logic             restart_o,
  output logic             trig50_o
);

  logic [CNT_W-1:0] cnt_q;
  int win_lo, win_hi, cnt_int;

  assign cnt_int = int'(cnt_q);

  always_comb begin
    if (!narrow_i) begin
      win_lo = SRCH_LO;
      win_hi = SRCH_HI;
    end else if (std50_i) begin
      win_lo = N50_LO;
      win_hi = N50_HI;
    end else begin
      win_lo = N60_LO;
      win_hi = N60_HI;
    end
  end

  always_comb begin
    evt_o = EV_IDLE;
    if (oos_i) begin
      if (cnt_int >= FREE_CNT) evt_o = EV_FREERUN;
    end else if (rise_i && in_span(cnt_int, win_lo, win_hi)) begin
      evt_o = EV_HIT;
    end else if (cnt_int >= win_hi) begin
      evt_o = EV_TIMEOUT;
    end else if (rise_i) begin
      evt_o = EV_STRAY;
    end
  end

  assign restart_o = evt_restarts(evt_o);
  assign trig50_o  = (cnt_int >= SPLIT);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)          cnt_q <= '0;
    else if (restart_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R2 R3: the count never runs past the wide window end
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(cnt_q) <= SRCH_HI);

  // R7: in narrow mode the count never passes the narrow window end
  a_r7_narrow_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    (narrow_i && !oos_i && $stable(narrow_i)) |-> (cnt_int <= win_hi));

endmodule

// File: rtl/vdiv_conf.sv
module vdiv_conf
  import vdiv_pkg::*;
#(
  parameter int CONF_W    = 4,
  parameter int CONF_DROP = 10
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  vdiv_evt_e         evt_i,
  input  logic              trig50_i,
  output logic [CONF_W-1:0] conf_o,
  output logic              narrow_o,
  output logic              std50_o
);

  localparam int CONF_MAX = (1 << CONF_W) - 1;

  logic [CONF_W-1:0] conf_q, conf_n;
  logic              narrow_q, std50_q;
  logic              step_up, step_dn;

  assign step_up = (evt_i == EV_HIT);
  assign step_dn = (evt_i == EV_TIMEOUT) || (evt_i == EV_STRAY);
  assign conf_n  = CONF_W'(conf_step(int'(conf_q), CONF_MAX, step_up, step_dn));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      conf_q   <= '0;
      narrow_q <= 1'b0;
      std50_q  <= 1'b1;
    end else begin
      conf_q <= conf_n;
      if (int'(conf_n) == CONF_MAX)     narrow_q <= 1'b1;
      else if (int'(conf_n) < CONF_DROP) narrow_q <= 1'b0;
      if (step_up && !narrow_q)          std50_q  <= trig50_i;
    end
  end

  assign conf_o   = conf_q;
  assign narrow_o = narrow_q;
  assign std50_o  = std50_q;

  // R5: confidence moves by at most one per clock
  a_r5_conf_step: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(conf_q) |-> ((int'(conf_q) == int'($past(conf_q)) + 1) ||
                          (int'(conf_q) + 1 == int'($past(conf_q)))));

  // R5: narrow mode starts only with full confidence
  a_r5_enter_full: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(narrow_q) |-> (int'(conf_q) == CONF_MAX));

  // R6: narrow mode ends exactly when confidence drops under the threshold
  a_r6_leave_low: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(narrow_q) |-> (int'(conf_q) == CONF_DROP - 1));

endmodule

// File: rtl/vdiv_gate.sv
module vdiv_gate #(
  parameter int CNT_W   = 10,
  parameter int END50   = 10,
  parameter int END60   = 12,
  parameter int EQ_LEAD = 6,
  parameter int N50_LO  = 622,
  parameter int N60_LO  = 522
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             narrow_i,
  input  logic             std50_i,
  input  logic             oos_i,
  output logic             gate_o
);

  localparam int LEAD50 = N50_LO - EQ_LEAD;
  localparam int LEAD60 = N60_LO - EQ_LEAD;

  int  c, gend, gstart;
  logic tail_on, lead_on;

  always_comb begin
    c       = int'(cnt_i);
    gend    = std50_i ? END50 : END60;
    gstart  = std50_i ? LEAD50 : LEAD60;
    tail_on = (c < gend);
    lead_on = narrow_i && !oos_i && (c >= gstart);
    gate_o  = tail_on || lead_on;
  end

endmodule

// File: rtl/vdiv_top.sv
module vdiv_top
  import vdiv_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int CONF_W    = 4,
  parameter int CONF_DROP = 10,
  parameter int SRCH_LO   = 488,
  parameter int SRCH_HI   = 722,
  parameter int N60_LO    = 522,
  parameter int N60_HI    = 528,
  parameter int N50_LO    = 622,
  parameter int N50_HI    = 628,
  parameter int FREE_CNT  = 625,
  parameter int SPLIT     = 576,
  parameter int END50     = 10,
  parameter int END60     = 12,
  parameter int EQ_LEAD   = 6
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic vsync_i,
  input  logic oos_i,
  output logic vrst_o,
  output logic std50_o,
  output logic narrow_o,
  output logic gate_o
);

  // Named internal events, visible to the assertions
  logic              sync_q, sync_rise;
  logic [CNT_W-1:0]  cnt;
  vdiv_evt_e         evt;
  logic              restart, trig50;
  logic [CONF_W-1:0] conf;
  logic              vrst_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= 1'b0;
      vrst_q <= 1'b0;
    end else begin
      sync_q <= vsync_i;
      vrst_q <= restart;
    end
  end

  assign sync_rise = vsync_i && !sync_q;
  assign vrst_o    = vrst_q;

  vdiv_count #(
    .CNT_W(CNT_W), .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI),
    .N60_LO(N60_LO), .N60_HI(N60_HI), .N50_LO(N50_LO), .N50_HI(N50_HI),
    .FREE_CNT(FREE_CNT), .SPLIT(SPLIT)
  ) u_count (
    .clk_i(clk_i), .rst_i(rst_i), .rise_i(sync_rise), .oos_i(oos_i),
    .narrow_i(narrow_o), .std50_i(std50_o),
    .cnt_o(cnt), .evt_o(evt), .restart_o(restart), .trig50_o(trig50)
  );

  vdiv_conf #(
    .CONF_W(CONF_W), .CONF_DROP(CONF_DROP)
  ) u_conf (
    .clk_i(clk_i), .rst_i(rst_i), .evt_i(evt), .trig50_i(trig50),
    .conf_o(conf), .narrow_o(narrow_o), .std50_o(std50_o)
  );

  vdiv_gate #(
    .CNT_W(CNT_W), .END50(END50), .END60(END60), .EQ_LEAD(EQ_LEAD),
    .N50_LO(N50_LO), .N60_LO(N60_LO)
  ) u_gate (
    .cnt_i(cnt), .narrow_i(narrow_o), .std50_i(std50_o), .oos_i(oos_i),
    .gate_o(gate_o)
  );

  // R11: frame strobe lasts one clock
  a_r11_vrst_single: assert property (@(posedge clk_i) disable iff (rst_i)
    vrst_o |=> !vrst_o);

  // R11: the strobe coincides with count zero
  a_r11_vrst_at_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    vrst_o |-> (cnt == '0));

  // R8 R9: the gate is open at every frame start
  a_r9_gate_at_start: assert property (@(posedge clk_i) disable iff (rst_i)
    vrst_o |-> gate_o);

  // R10: out-of-sync freezes confidence and both flags
  a_r10_oos_freeze: assert property (@(posedge clk_i) disable iff (rst_i)
    oos_i |=> ($stable(conf) && $stable(std50_o) && $stable(narrow_o)));

  // R12: a sync edge is never seen twice in a row
  a_r12_edge_once: assert property (@(posedge clk_i) disable iff (rst_i)
    sync_rise |=> !sync_rise);

endmodule

// File: tb/test_vdiv_top.sv
module test_vdiv_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync = 1'b0;
  logic oos = 1'b0;
  logic vrst, std50, narrow, gate;

  int checks = 0;
  int errors = 0;

  localparam int NONE = 5000;

  typedef struct packed {
    int pos;   // sync count (NONE = no sync)
    int oos;
    int rc;    // expected restart count
    int std;   // expected 50 Hz flag after the field
    int nar;   // expected narrow flag after the field
    int gend;  // expected first count with gate low
    int gon;   // expected first count >= 100 with gate high (-1 none)
  } vec_t;

  localparam int NV = 43;
  localparam vec_t TBL [NV] = '{
    '{524,0,524,0,0,10,-1},
    '{524,0,524,0,0,12,-1}, '{524,0,524,0,0,12,-1}, '{524,0,524,0,0,12,-1},
    '{524,0,524,0,0,12,-1}, '{524,0,524,0,0,12,-1}, '{524,0,524,0,0,12,-1},
    '{524,0,524,0,0,12,-1}, '{524,0,524,0,0,12,-1}, '{524,0,524,0,0,12,-1},
    '{524,0,524,0,0,12,-1}, '{524,0,524,0,0,12,-1}, '{524,0,524,0,0,12,-1},
    '{524,0,524,0,0,12,-1},
    '{524,0,524,0,1,12,-1},
    '{524,0,524,0,1,12,516},
    '{NONE,0,528,0,1,12,516}, '{NONE,0,528,0,1,12,516}, '{NONE,0,528,0,1,12,516},
    '{NONE,0,528,0,1,12,516}, '{NONE,0,528,0,1,12,516},
    '{NONE,0,528,0,0,12,516},
    '{NONE,0,722,0,0,12,-1},
    '{625,0,625,1,0,12,-1},
    '{575,0,575,0,0,10,-1},
    '{576,0,576,1,0,12,-1},
    '{487,0,722,1,0,10,-1},
    '{488,0,488,0,0,10,-1},
    '{722,0,722,1,0,12,-1},
    '{530,1,625,1,0,10,-1},
    '{NONE,1,625,1,0,10,-1},
    '{700,0,700,1,0,10,-1},
    '{625,0,625,1,0,10,-1}, '{625,0,625,1,0,10,-1},
    '{625,0,625,1,1,10,-1},
    '{625,0,625,1,1,10,616},
    '{620,0,628,1,1,10,616},
    '{622,0,622,1,1,10,616},
    '{628,0,628,1,1,10,616},
    '{629,0,628,1,1,10,616},
    '{650,0,628,1,1,10,616},
    '{NONE,1,625,1,1,10,-1},
    '{625,0,625,1,1,10,616}
  };

  vdiv_top i_vdiv_top (
    .clk_i(clk), .rst_i(rst), .vsync_i(vsync), .oos_i(oos),
    .vrst_o(vrst), .std50_o(std50), .narrow_o(narrow), .gate_o(gate)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one field from count 0; returns restart count and gate edges
  task automatic run_frame(input int pos, input int len, input int o,
                           output int rc, output int gend, output int gon);
    rc = -1; gend = -1; gon = -1;
    for (int k = 0; k < 1100; k++) begin
      vsync = (k >= pos) && (k < pos + len);
      oos   = o[0];
      #1;
      if (gend < 0 && !gate) gend = k;
      if (gon < 0 && k >= 100 && gate) gon = k;
      @(negedge clk);
      if (vrst) begin
        rc = k;
        break;
      end
    end
    vsync = 1'b0;
    oos   = 1'b0;
  endtask

  task automatic chk_reset_state();
    chk("R1 strobe", int'(vrst), 0);
    chk("R1 narrow", int'(narrow), 0);
    chk("R1 std50", int'(std50), 1);
    chk("R1 gate", int'(gate), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rc, ge, go;
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst = 1'b0;

    // Vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      run_frame(TBL[i].pos, 1, TBL[i].oos, rc, ge, go);
      chk($sformatf("R3 R7 R10 R11 restart row %0d", i), rc, TBL[i].rc);
      chk($sformatf("R4 std50 row %0d", i), int'(std50), TBL[i].std);
      chk($sformatf("R5 R6 narrow row %0d", i), int'(narrow), TBL[i].nar);
      chk($sformatf("R8 gate end row %0d", i), ge, TBL[i].gend);
      chk($sformatf("R9 gate lead row %0d", i), go, TBL[i].gon);
    end

    // Reset in the middle of a narrow-mode field returns to R1 state
    repeat (200) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_reset_state();
    rst = 1'b0;

    // R12: sync rises at 480 (outside window) and stays high through it
    run_frame(480, 300, 0, rc, ge, go);
    chk("R12 held sync not re-accepted", rc, 722);
    chk("R12 std50 unchanged", int'(std50), 1);

    // R2: no sync at all, self restart at 722
    run_frame(NONE, 1, 0, rc, ge, go);
    chk("R2 free restart", rc, 722);
    chk("R2 still wide", int'(narrow), 0);

    // R3: plain accepted trigger in the wide window
    run_frame(600, 1, 0, rc, ge, go);
    chk("R3 accept 600", rc, 600);
    chk("R4 std50 at 600", int'(std50), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule